// File: doc/BRIEF.md
# Configurable 8-bit float decoder

This block widens one 8-bit code, written in a floating-point format whose layout is set by configuration inputs, into an IEEE single-precision (FP32) word. Three settings define the format: the width of the exponent field, an exponent bias that is programmed on its own rather than derived from that width, and whether a sign bit is present. The fraction takes whatever bits the sign and exponent leave free. When the sign is switched off, its bit becomes part of the magnitude and every value is non-negative.

A code and its configuration are sampled together on a clock edge where `in_vld` is high. The FP32 result appears one cycle later with `out_vld`. Zero codes, subnormal codes, results too large for FP32 and results too small for a normal FP32 number are all handled in the block. The format has no infinity or NaN codes: an all-ones exponent is an ordinary finite binade.

Top module: `f8w_widen`

## Requirements
- R1: With `cfg_sign_en`=1, bit 7 is the sign, the next `cfg_exp_w` bits below it are the exponent field, and the low 7−`cfg_exp_w` bits are the fraction. With `cfg_sign_en`=0, the top `cfg_exp_w` bits are the exponent, the low 8−`cfg_exp_w` bits are the fraction, and the output sign bit 31 is 0.
- R2: For a nonzero exponent field E with fraction F of width W, the output is {sign, E − bias + 127 in bits 30:23, F left-aligned in bits 22:0}, i.e. the value (1 + F/2^W)·2^(E−bias).
- R3: `cfg_bias` is an 8-bit two's-complement input used as given. With a 5-bit exponent, the sign on and bias 15, code 0x3C gives 0x3F800000, 0xBC gives 0xBF800000 and 0x7F gives 0x47E00000.
- R4: An exponent field of 0 with a nonzero fraction is a subnormal of value F/2^W · 2^(1−bias), and it is output as the normalised FP32 number of that value.
- R5: An exponent field of 0 with a zero fraction gives signed zero: 0x00000000, or 0x80000000 when the sign bit is 1.
- R6: The all-ones exponent field decodes as a finite value by the rule in R2; the output exponent field (bits 30:23) is never 0xFF.
- R7: When the FP32 biased exponent would exceed 254, the output saturates to {sign, 0xFE, 0x7FFFFF}.
- R8: When the FP32 biased exponent would be below 1, the output is signed zero.
- R9: A `cfg_exp_w` outside 2..7 makes the output word 0x00000000 with `out_err`=1; in every legal configuration `out_err`=0.
- R10: `out_vld` equals `in_vld` from the previous clock. `out_word` and `out_err` change only on a clock where `in_vld` is high and hold otherwise. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Code and configuration are sampled this clock |
| in_code | input | 8 | Encoded value |
| cfg_exp_w | input | 3 | Exponent field width, legal 2 to 7 |
| cfg_bias | input | 8 | Exponent bias, two's complement |
| cfg_sign_en | input | 1 | 1: bit 7 is a sign bit |
| out_vld | output | 1 | Result valid, one clock after in_vld |
| out_word | output | 32 | FP32 result |
| out_err | output | 1 | Illegal exponent width for this result |

## Verification
Every result is due exactly one clock after the edge that samples `in_vld`, and the hold behaviour means the word and flag must also be unchanged on every clock where no code was taken. The bench drives inputs on the falling edge, computes the expected output from the inputs present at the rising edge with a real-number model, and compares all three outputs on the following falling edge, so that every cycle, valid or idle, is checked against the one-cycle rule.

// File: rtl/f8w_pkg.sv
package f8w_pkg;
  localparam int CODE_W    = 8;
  localparam int EW_W      = 3;
  localparam int FW_W      = $clog2(CODE_W + 1);
  localparam int LEAD_W    = $clog2(CODE_W);
  localparam int BIAS_W    = 8;
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 23;
  localparam int FP_BIAS   = 127;
  localparam int FP_EMAX   = 254;
  localparam int BX_W      = 11;
  localparam int EXP_MIN   = 2;
  localparam int EXP_MAX   = 7;

  // True when the exponent width is outside the supported range.
  function automatic logic width_illegal(input logic [EW_W-1:0] ew);
    return (int'(ew) < EXP_MIN) || (int'(ew) > EXP_MAX);
  endfunction

  // Number of fraction bits left after sign and exponent.
  function automatic logic [FW_W-1:0] frac_width(input logic [EW_W-1:0] ew,
                                                 input logic sign_en);
    return FW_W'(CODE_W - int'(ew) - int'(sign_en));
  endfunction

  // Unbiased exponent shift for a subnormal with leading one at 'lead'.
  function automatic logic signed [BX_W-1:0] sub_exp(input logic [LEAD_W-1:0] lead,
                                                     input logic [FW_W-1:0] fw);
    return BX_W'(int'(lead) - int'(fw) + 1);
  endfunction

  // FP32 biased exponent from the pre-bias exponent and the programmed bias.
  function automatic logic signed [BX_W-1:0] rebias(input logic signed [BX_W-1:0] pre,
                                                    input logic [BIAS_W-1:0] bias);
    logic signed [BX_W-1:0] bias_x;
    bias_x = $signed({{(BX_W-BIAS_W){bias[BIAS_W-1]}}, bias});
    return pre - bias_x + BX_W'(FP_BIAS);
  endfunction
endpackage

// File: rtl/f8w_unpack.sv
module f8w_unpack
  import f8w_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [EW_W-1:0]   exp_w,
  input  logic              sign_en,
  output logic              sign,
  output logic [CODE_W-1:0] exp_field,
  output logic [CODE_W-1:0] frac_field,
  output logic [FW_W-1:0]   frac_w,
  output logic              cfg_bad
);
  logic [CODE_W-1:0] emask;
  logic [CODE_W-1:0] fmask;
  logic [FW_W-1:0]   fw_raw;

  assign cfg_bad = width_illegal(exp_w);
  assign fw_raw  = frac_width(exp_w, sign_en);
  assign frac_w  = cfg_bad ? '0 : fw_raw;

  // One mask bit per code position; the widths pick which bits belong.
  for (genvar i = 0; i < CODE_W; i++) begin : g_mask
    assign emask[i] = !cfg_bad && (EW_W'(i) < exp_w) && (i <= EXP_MAX);
    assign fmask[i] = !cfg_bad && (FW_W'(i) < fw_raw);
  end

  always_comb begin
    exp_field  = (code >> frac_w) & emask;
    frac_field = code & fmask;
    sign       = !cfg_bad && sign_en && code[CODE_W-1];
  end
endmodule

// File: rtl/f8w_norm.sv
module f8w_norm
  import f8w_pkg::*;
(
  input  logic [CODE_W-1:0]      exp_field,
  input  logic [CODE_W-1:0]      frac_field,
  input  logic [FW_W-1:0]        frac_w,
  output logic                   is_zero,
  output logic                   is_sub,
  output logic signed [BX_W-1:0] pre_exp,
  output logic [FP_FRAC_W-1:0]   frac_out
);
  logic [LEAD_W-1:0]    lead;
  logic [FP_FRAC_W-1:0] frac_ext;
  logic                 exp_nz;
  logic                 frac_nz;

  assign exp_nz   = |exp_field;
  assign frac_nz  = |frac_field;
  assign is_zero  = !exp_nz && !frac_nz;
  assign is_sub   = !exp_nz && frac_nz;
  assign frac_ext = FP_FRAC_W'(frac_field);

  // Leading-one search; the highest set bit wins.
  always_comb begin
    lead = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (frac_field[i]) lead = LEAD_W'(i);
    end
  end

  always_comb begin
    if (is_sub) begin
      // The leading one becomes the hidden bit and drops off the top.
      frac_out = frac_ext << (FP_FRAC_W - int'(lead));
      pre_exp  = sub_exp(lead, frac_w);
    end else begin
      frac_out = frac_ext << (FP_FRAC_W - int'(frac_w));
      pre_exp  = BX_W'(exp_field);
    end
  end
endmodule

// File: rtl/f8w_pack.sv
module f8w_pack
  import f8w_pkg::*;
(
  input  logic                   sign,
  input  logic                   is_zero,
  input  logic                   cfg_bad,
  input  logic signed [BX_W-1:0] pre_exp,
  input  logic [BIAS_W-1:0]      bias,
  input  logic [FP_FRAC_W-1:0]   frac_in,
  output logic                   sat_evt,
  output logic                   uflow_evt,
  output logic [31:0]            word
);
  logic signed [BX_W-1:0] biased;

  assign biased    = rebias(pre_exp, bias);
  assign sat_evt   = !cfg_bad && !is_zero && (biased > BX_W'(FP_EMAX));
  assign uflow_evt = !cfg_bad && !is_zero && (biased < BX_W'(1));

  always_comb begin
    if (cfg_bad)
      word = '0;
    else if (is_zero || uflow_evt)
      word = {sign, 31'd0};
    else if (sat_evt)
      word = {sign, FP_EXP_W'(FP_EMAX), {FP_FRAC_W{1'b1}}};
    else
      word = {sign, biased[FP_EXP_W-1:0], frac_in};
  end
endmodule

// File: rtl/f8w_widen.sv
module f8w_widen
  import f8w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [CODE_W-1:0] in_code,
  input  logic [EW_W-1:0]   cfg_exp_w,
  input  logic [BIAS_W-1:0] cfg_bias,
  input  logic              cfg_sign_en,
  output logic              out_vld,
  output logic [31:0]       out_word,
  output logic              out_err
);
  logic                   u_sign;
  logic [CODE_W-1:0]      u_exp;
  logic [CODE_W-1:0]      u_frac;
  logic [FW_W-1:0]        u_fw;
  logic                   cfg_bad;
  logic                   n_zero;
  logic                   n_sub;
  logic signed [BX_W-1:0] n_pre;
  logic [FP_FRAC_W-1:0]   n_frac;
  logic                   sat_evt;
  logic                   uflow_evt;
  logic [31:0]            next_word;

  f8w_unpack u_unpack (
    .code(in_code), .exp_w(cfg_exp_w), .sign_en(cfg_sign_en),
    .sign(u_sign), .exp_field(u_exp), .frac_field(u_frac),
    .frac_w(u_fw), .cfg_bad(cfg_bad)
  );

  f8w_norm u_norm (
    .exp_field(u_exp), .frac_field(u_frac), .frac_w(u_fw),
    .is_zero(n_zero), .is_sub(n_sub), .pre_exp(n_pre), .frac_out(n_frac)
  );

  f8w_pack u_pack (
    .sign(u_sign), .is_zero(n_zero), .cfg_bad(cfg_bad), .pre_exp(n_pre),
    .bias(cfg_bias), .frac_in(n_frac), .sat_evt(sat_evt),
    .uflow_evt(uflow_evt), .word(next_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_word <= '0;
      out_err  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_word <= next_word;
        out_err  <= cfg_bad;
      end
    end
  end

  // R10
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld && rst_n));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_word) && $stable(out_err)));

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_word == 32'd0));

  // R6
  no_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_word[30:23] != 8'hFF));

  // R1
  unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !cfg_sign_en) |=> !out_word[31]);

  // R7
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && sat_evt) |=> (out_word[30:0] == 31'h7F7FFFFF));

  // R8
  uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && uflow_evt) |=> (out_word[30:0] == 31'd0));

  // R4
  sub_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && n_sub && !uflow_evt && !sat_evt) |=> (out_word[30:23] != 8'h00));
endmodule

// File: tb/tb_f8w_widen.sv
`timescale 1ns/1ps
module tb_f8w_widen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [7:0]  in_code = '0;
  logic [2:0]  cfg_exp_w = 3'd4;
  logic [7:0]  cfg_bias = '0;
  logic        cfg_sign_en = 1'b1;
  logic        out_vld;
  logic [31:0] out_word;
  logic        out_err;

  int checks = 0;
  int failures = 0;

  logic        m_vld = 1'b0;
  logic [31:0] m_word = '0;
  logic        m_err = 1'b0;
  string       m_tag = "R10";

  always #2.5 clk = ~clk;

  f8w_widen dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_code(in_code),
    .cfg_exp_w(cfg_exp_w), .cfg_bias(cfg_bias), .cfg_sign_en(cfg_sign_en),
    .out_vld(out_vld), .out_word(out_word), .out_err(out_err)
  );

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  // Behavioural model: decode to a real value, then round-trip through double bits.
  task automatic model(input logic [7:0] code, input logic sgn_en, input logic [2:0] ew,
                       input logic [7:0] bias, output logic [31:0] w, output logic err,
                       output string tag);
    int fw, e, f, b, se;
    logic s;
    real mag;
    logic [63:0] bits;
    err = 0;
    if (ew < 2 || ew > 7) begin
      w = 0; err = 1; tag = "R9"; return;
    end
    fw = 8 - int'(ew) - int'(sgn_en);
    e = (int'(code) >> fw) & ((1 << ew) - 1);
    f = int'(code) & ((1 << fw) - 1);
    s = sgn_en && code[7];
    b = int'($signed(bias));
    if (e == 0 && f == 0) begin
      w = {s, 31'd0}; tag = "R5"; return;
    end
    if (e != 0) mag = (1.0 + real'(f) / pow2(fw)) * pow2(e - b);
    else        mag = (real'(f) / pow2(fw)) * pow2(1 - b);
    bits = $realtobits(mag);
    se = int'(bits[62:52]) - 1023 + 127;
    if (se > 254) begin
      w = {s, 8'hFE, 23'h7FFFFF}; tag = "R7";
    end else if (se < 1) begin
      w = {s, 31'd0}; tag = "R8";
    end else begin
      w = {s, se[7:0], bits[51:29]};
      if (e == 0) tag = "R4";
      else if (e == (1 << ew) - 1) tag = "R6";
      else if (!sgn_en) tag = "R1";
      else tag = "R2";
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // One clock: inputs set at a falling edge, model at the rising edge, compare at the next falling edge.
  task automatic step(input logic v, input logic [7:0] c, input logic se,
                      input logic [2:0] ew, input logic [7:0] b);
    logic [31:0] w;
    logic er;
    string tg;
    in_vld = v; in_code = c; cfg_sign_en = se; cfg_exp_w = ew; cfg_bias = b;
    @(posedge clk);
    m_vld = v;
    if (v) begin
      model(c, se, ew, b, w, er, tg);
      m_word = w; m_err = er; m_tag = tg;
    end else begin
      m_tag = "R10";
    end
    @(negedge clk);
    check("R10", {31'd0, out_vld}, {31'd0, m_vld});
    check(m_tag, out_word, m_word);
    check(m_tag == "R9" ? "R9" : m_tag, {31'd0, out_err}, {31'd0, m_err});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] biases [5];
    biases[0] = 8'd15; biases[1] = 8'd0; biases[2] = 8'd127;
    biases[3] = 8'h80; biases[4] = 8'd3;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {30'd0, out_vld, out_err}, 32'd0);
    check("R10", out_word, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 half-precision-like layout with bias 15
    step(1, 8'h3C, 1, 3'd5, 8'd15);
    check("R3", out_word, 32'h3F800000);
    step(1, 8'hBC, 1, 3'd5, 8'd15);
    check("R3", out_word, 32'hBF800000);
    step(1, 8'h7F, 1, 3'd5, 8'd15);
    check("R3", out_word, 32'h47E00000);
    // R5 negative zero
    step(1, 8'h80, 1, 3'd4, 8'd7);
    check("R5", out_word, 32'h80000000);

    // Sweep every code over sign modes, legal widths and several biases.
    for (int sm = 0; sm < 2; sm++)
      for (int ew = 2; ew <= 7; ew++)
        for (int bi = 0; bi < 5; bi++)
          for (int c = 0; c < 256; c++)
            step((c % 11) != 5, 8'(c), sm[0], 3'(ew), biases[bi]);

    // R9 illegal widths, then recovery to a legal one
    for (int ew = 0; ew < 2; ew++)
      for (int c = 0; c < 16; c++)
        step(1, 8'(c * 13 + 1), c[0], 3'(ew), 8'd5);
    step(1, 8'h41, 1, 3'd4, 8'd7);
    check("R9", {31'd0, out_err}, 32'd0);

    // R10 idle cycles with changing inputs must leave the outputs alone
    step(1, 8'h55, 0, 3'd3, 8'd2);
    for (int k = 0; k < 8; k++) step(0, 8'(k * 37), k[0], 3'(k), 8'(k * 29));
    step(1, 8'h55, 0, 3'd3, 8'd2);
    step(1, 8'hAA, 0, 3'd3, 8'd2);

    in_vld = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule